// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block caches page-translation entries for a 20-bit virtual page number in 16 sets of 4 ways. Each way stores a valid bit, a kind flag (1 when it holds a directory-level entry, 0 for a table-level entry), a 16-bit tag and the 32-bit cached entry. A lookup is sampled on a clock edge and its result appears in registers one cycle later. It reports a full translation hit with the physical address, a directory-only hit so the walker can skip the directory fetch, or a miss.

On a miss an external walker fetches the entries and installs them through the fill port. Replacement prefers an empty way and otherwise follows a 3-bit tree pseudo-LRU per set. A write to the directory base register flushes every entry whose global bit is clear in a single cycle. A write that hits a clean page is reported as a miss, so the walker can set the dirty bit in memory.

Top module: `tlb`

## Requirements
- R1: After reset every way is invalid. A lookup sampled at a clock edge raises `respValid` for exactly the following cycle, and a lookup of an empty TLB reports neither `respHit` nor `respDirHit`.
- R2: The set is `vpn[3:0]` and the tag is `vpn[19:4]`. Four table entries with distinct tags in one set all remain resident, and a fifth tag in that set misses.
- R3: A table-kind match reports `respHit`, `respEntry` equal to the stored entry, and `respPaddr = {entry[31:12], lookupOffset}`.
- R4: A directory-kind entry (`fillIsDir=1`) never produces `respHit`. When it matches and no table entry matches, it produces `respDirHit` with `respEntry` equal to that entry and `respPaddr` equal to 0.
- R5: Filling a tag and kind that are already resident in the set overwrites that way in place. The other ways of the set are left untouched.
- R6: A fill into a set that has an invalid way uses the lowest-numbered invalid way. It never evicts a valid entry.
- R7: With all ways valid, the victim is chosen by a 3-bit tree (root, left pair, right pair). Any lookup match or fill points the tree away from the way it used, and at reset the tree points at way 0.
- R8: A lookup with `lookupWrite=1` that matches a table entry whose dirty bit (entry bit 6) is 0 reports a miss. If the dirty bit is 1 it reports a hit.
- R9: `baseWrite` clears every entry whose global bit (entry bit 8) is 0 and keeps every global entry. A lookup sampled in the same cycle as `baseWrite` still sees the contents from before the flush.
- R10: A fill presented in the same cycle as `baseWrite` is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | Lookup request this cycle |
| lookupVpn | input | 20 | Virtual page number to translate |
| lookupOffset | input | 12 | Page offset joined to the frame on a hit |
| lookupWrite | input | 1 | The access is a write |
| fillValid | input | 1 | Install an entry this cycle |
| fillVpn | input | 20 | Virtual page number of the installed entry |
| fillIsDir | input | 1 | 1 = directory-level entry, 0 = table-level entry |
| fillEntry | input | 32 | Entry value to cache |
| baseWrite | input | 1 | Directory base register written: flush non-global entries |
| respValid | output | 1 | Lookup result valid |
| respHit | output | 1 | Full translation hit |
| respDirHit | output | 1 | Directory-level entry cached for this page |
| respPaddr | output | 32 | Physical address on a hit, else 0 |
| respEntry | output | 32 | Matched entry, table kind preferred, else 0 |

## Verification
Two events can share a cycle. The first is a flush together with a lookup. The second is a flush together with a walker fill. The bench raises `baseWrite` in the same cycle as a lookup of a cached non-global page and expects a hit from the old contents. It then expects a miss on the very next lookup of that page. It also raises `baseWrite` alongside a fill whose entry is marked global, so that only discarding the fill explains a later miss, since a flush would have kept a global entry.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int WAYS   = 4;
  localparam int WAY_W  = 2;
  localparam int PLRU_W = 3;

  typedef struct packed {
    logic capture;  // register this cycle's lookup result
    logic touch;    // update the tree of the looked-up set
    logic fill;     // install the walker's entry
    logic flush;    // clear non-global entries
  } tlb_strobes_t;

  // Tree bits: [0] root (0 = left pair), [1] left pair, [2] right pair
  function automatic logic [WAY_W-1:0] plruVictim(input logic [PLRU_W-1:0] p);
    if (p[0]) return p[2] ? 2'd3 : 2'd2;
    else      return p[1] ? 2'd1 : 2'd0;
  endfunction

  function automatic logic [PLRU_W-1:0] plruTouch(input logic [PLRU_W-1:0] p,
                                                  input logic [WAY_W-1:0] way);
    logic [PLRU_W-1:0] n;
    n = p;
    case (way)
      2'd0: begin n[0] = 1'b1; n[1] = 1'b1; end
      2'd1: begin n[0] = 1'b1; n[1] = 1'b0; end
      2'd2: begin n[0] = 1'b0; n[2] = 1'b1; end
      default: begin n[0] = 1'b0; n[2] = 1'b0; end
    endcase
    return n;
  endfunction
endpackage

// File: rtl/tlb_control.sv
module tlb_control
  import tlb_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         lookupValid,
  input  logic         fillValid,
  input  logic         baseWrite,
  input  logic         anyMatch,
  input  logic         sameSet,
  output tlb_strobes_t strb,
  output logic         respValid
);
  logic fillGo;

  // R10: the flush has priority and the fill is dropped
  assign fillGo = fillValid && !baseWrite;

  always_comb begin
    strb.flush   = baseWrite;
    strb.fill    = fillGo;
    strb.capture = lookupValid;
    // a fill into the same set owns the tree this cycle
    strb.touch   = lookupValid && anyMatch && !(fillGo && sameSet);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) respValid <= 1'b0;
    else       respValid <= lookupValid;
  end
endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int VPN_W      = 20,
  parameter int IDX_W      = 4,
  parameter int OFF_W      = 12,
  parameter int ENTRY_W    = 32,
  parameter int GLOBAL_BIT = 8,
  parameter int DIRTY_BIT  = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  tlb_strobes_t       strb,
  input  logic [VPN_W-1:0]   lookupVpn,
  input  logic [OFF_W-1:0]   lookupOffset,
  input  logic               lookupWrite,
  input  logic [VPN_W-1:0]   fillVpn,
  input  logic               fillIsDir,
  input  logic [ENTRY_W-1:0] fillEntry,
  output logic               anyMatch,
  output logic               sameSet,
  output logic               respHit,
  output logic               respDirHit,
  output logic [ENTRY_W-1:0] respPaddr,
  output logic [ENTRY_W-1:0] respEntry
);
  localparam int SETS    = 1 << IDX_W;
  localparam int TAG_W   = VPN_W - IDX_W;
  localparam int FRAME_W = ENTRY_W - OFF_W;

  logic [WAYS-1:0]    validQ [SETS];
  logic [WAYS-1:0]    isDirQ [SETS];
  logic [TAG_W-1:0]   tagQ   [SETS][WAYS];
  logic [ENTRY_W-1:0] entryQ [SETS][WAYS];
  logic [PLRU_W-1:0]  plruQ  [SETS];

  logic [IDX_W-1:0] lSet, fSet;
  logic [TAG_W-1:0] lTag, fTag;
  assign lSet = lookupVpn[IDX_W-1:0];
  assign lTag = lookupVpn[VPN_W-1:IDX_W];
  assign fSet = fillVpn[IDX_W-1:0];
  assign fTag = fillVpn[VPN_W-1:IDX_W];
  assign sameSet = (lSet == fSet);

  logic [WAYS-1:0] tblMatch, dirMatch, fillSame;
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign tblMatch[w] = validQ[lSet][w] && !isDirQ[lSet][w] && (tagQ[lSet][w] == lTag);
    assign dirMatch[w] = validQ[lSet][w] &&  isDirQ[lSet][w] && (tagQ[lSet][w] == lTag);
    assign fillSame[w] = validQ[fSet][w] && (isDirQ[fSet][w] == fillIsDir)
                         && (tagQ[fSet][w] == fTag);
  end

  logic               tblAny, dirAny;
  logic [ENTRY_W-1:0] tblEnt, dirEnt;
  logic [WAY_W-1:0]   tblWay, dirWay, hitWay, fillWay;

  assign tblAny   = |tblMatch;
  assign dirAny   = |dirMatch;
  assign anyMatch = tblAny || dirAny;
  assign hitWay   = tblAny ? tblWay : dirWay;

  // lowest matching way wins (descending loop, last assignment kept)
  always_comb begin
    tblEnt = '0; tblWay = '0; dirEnt = '0; dirWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (tblMatch[w]) begin tblEnt = entryQ[lSet][w]; tblWay = WAY_W'(w); end
      if (dirMatch[w]) begin dirEnt = entryQ[lSet][w]; dirWay = WAY_W'(w); end
    end
  end

  // priority: same tag and kind > lowest invalid > tree victim
  always_comb begin
    fillWay = plruVictim(plruQ[fSet]);
    for (int w = WAYS - 1; w >= 0; w--)
      if (!validQ[fSet][w]) fillWay = WAY_W'(w);
    for (int w = WAYS - 1; w >= 0; w--)
      if (fillSame[w]) fillWay = WAY_W'(w);
  end

  logic cleanWrite;
  assign cleanWrite = lookupWrite && !tblEnt[DIRTY_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validQ[s] <= '0;
        plruQ[s]  <= '0;
      end
      respHit    <= 1'b0;
      respDirHit <= 1'b0;
      respPaddr  <= '0;
      respEntry  <= '0;
    end else begin
      if (strb.flush)
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++)
            if (!entryQ[s][w][GLOBAL_BIT]) validQ[s][w] <= 1'b0;
      if (strb.touch) plruQ[lSet] <= plruTouch(plruQ[lSet], hitWay);
      if (strb.fill) begin
        validQ[fSet][fillWay] <= 1'b1;
        plruQ[fSet]           <= plruTouch(plruQ[fSet], fillWay);
      end
      respHit    <= strb.capture && tblAny && !cleanWrite;
      respDirHit <= strb.capture && dirAny;
      respPaddr  <= (strb.capture && tblAny && !cleanWrite)
                    ? {tblEnt[ENTRY_W-1 -: FRAME_W], lookupOffset} : '0;
      respEntry  <= !strb.capture ? '0 : tblAny ? tblEnt : dirAny ? dirEnt : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.fill) begin
      isDirQ[fSet][fillWay] <= fillIsDir;
      tagQ[fSet][fillWay]   <= fTag;
      entryQ[fSet][fillWay] <= fillEntry;
    end
  end
endmodule

// File: rtl/tlb.sv
module tlb
  import tlb_pkg::*;
#(
  parameter int VPN_W      = 20,
  parameter int IDX_W      = 4,
  parameter int OFF_W      = 12,
  parameter int ENTRY_W    = 32,
  parameter int GLOBAL_BIT = 8,
  parameter int DIRTY_BIT  = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lookupValid,
  input  logic [VPN_W-1:0]   lookupVpn,
  input  logic [OFF_W-1:0]   lookupOffset,
  input  logic               lookupWrite,
  input  logic               fillValid,
  input  logic [VPN_W-1:0]   fillVpn,
  input  logic               fillIsDir,
  input  logic [ENTRY_W-1:0] fillEntry,
  input  logic               baseWrite,
  output logic               respValid,
  output logic               respHit,
  output logic               respDirHit,
  output logic [ENTRY_W-1:0] respPaddr,
  output logic [ENTRY_W-1:0] respEntry
);
  tlb_strobes_t strb;
  logic anyMatch, sameSet;

  tlb_control u_ctrl (
    .clk, .rstN, .lookupValid, .fillValid, .baseWrite,
    .anyMatch, .sameSet, .strb, .respValid
  );

  tlb_datapath #(
    .VPN_W(VPN_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .ENTRY_W(ENTRY_W),
    .GLOBAL_BIT(GLOBAL_BIT), .DIRTY_BIT(DIRTY_BIT)
  ) u_dp (
    .clk, .rstN, .strb, .lookupVpn, .lookupOffset, .lookupWrite,
    .fillVpn, .fillIsDir, .fillEntry, .anyMatch, .sameSet,
    .respHit, .respDirHit, .respPaddr, .respEntry
  );
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
  parameter int OFF_W     = 12,
  parameter int ENTRY_W   = 32,
  parameter int DIRTY_BIT = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               lookupValid,
  input logic [OFF_W-1:0]   lookupOffset,
  input logic               lookupWrite,
  input logic               respValid,
  input logic               respHit,
  input logic               respDirHit,
  input logic [ENTRY_W-1:0] respPaddr,
  input logic [ENTRY_W-1:0] respEntry
);
  // R1
  resp_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> respValid);

  // R1
  no_stray_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !respValid);

  // R3
  hit_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> (!respHit || respPaddr[OFF_W-1:0] == $past(lookupOffset)));

  // R3
  hit_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    respHit |-> respPaddr[ENTRY_W-1:OFF_W] == respEntry[ENTRY_W-1:OFF_W]);

  // R8
  clean_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && lookupWrite) |=> (!respHit || respEntry[DIRTY_BIT]));

  // R4
  dir_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respHit && !respDirHit) |-> (respPaddr == '0 && respEntry[DIRTY_BIT:0] == '0)
      || $past(lookupWrite));
endmodule

bind tlb tlb_checker #(.OFF_W(OFF_W), .ENTRY_W(ENTRY_W), .DIRTY_BIT(DIRTY_BIT)) u_chk (
  .clk, .rstN, .lookupValid, .lookupOffset, .lookupWrite,
  .respValid, .respHit, .respDirHit, .respPaddr, .respEntry
);

// File: tb/test_tlb.sv
`timescale 1ns/1ps
module test_tlb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0, lookupWrite = 1'b0;
  logic [19:0] lookupVpn = '0, fillVpn = '0;
  logic [11:0] lookupOffset = '0;
  logic        fillValid = 1'b0, fillIsDir = 1'b0, baseWrite = 1'b0;
  logic [31:0] fillEntry = '0;
  logic        respValid, respHit, respDirHit;
  logic [31:0] respPaddr, respEntry;

  always #4 clk = ~clk;

  tlb i_tlb (.*);

  int nChk = 0, nFail = 0;
  logic gotV, gotHit, gotDir;
  logic [31:0] gotPa, gotEnt;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] frameOf(input logic [19:0] v);
    return v ^ 20'h5A3C1;
  endfunction

  function automatic logic [31:0] entOf(input logic [19:0] v, input bit g, input bit d);
    return {frameOf(v), 3'b000, g, 1'b0, d, 5'b00000, 1'b1};
  endfunction

  function automatic logic [19:0] vpnAt(input int k, input int s);
    return {16'(k * 16'h1111 + 16'h0100), 4'(s)};
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic look(input logic [19:0] v, input logic [11:0] off, input bit wr, input bit flush);
    @(negedge clk);
    lookupValid = 1'b1; lookupVpn = v; lookupOffset = off; lookupWrite = wr; baseWrite = flush;
    @(negedge clk);
    lookupValid = 1'b0; lookupWrite = 1'b0; baseWrite = 1'b0;
    gotV = respValid; gotHit = respHit; gotDir = respDirHit; gotPa = respPaddr; gotEnt = respEntry;
  endtask

  task automatic fill(input logic [19:0] v, input bit dir, input logic [31:0] e, input bit flush);
    @(negedge clk);
    fillValid = 1'b1; fillVpn = v; fillIsDir = dir; fillEntry = e; baseWrite = flush;
    @(negedge clk);
    fillValid = 1'b0; baseWrite = 1'b0;
  endtask

  task automatic expectHit(input logic [19:0] v, input logic [31:0] e, input string req);
    logic [11:0] off;
    off = v[11:0] ^ 12'hABC;
    look(v, off, 1'b0, 1'b0);
    check(gotV && gotHit, req, {30'b0, gotV, gotHit}, 32'h3);
    check(gotPa == {e[31:12], off}, req, gotPa, {e[31:12], off});
  endtask

  task automatic expectMiss(input logic [19:0] v, input string req);
    look(v, 12'h123, 1'b0, 1'b0);
    check(gotV && !gotHit, req, {30'b0, gotV, gotHit}, 32'h2);
  endtask

  initial begin
    #(8 * 200000);
    nChk++; nFail++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    doReset();
    // R1: empty after reset
    look(20'h12345, 12'h0, 1'b0, 1'b0);
    check(gotV && !gotHit && !gotDir, "R1 reset", {29'b0, gotV, gotHit, gotDir}, 32'h4);
    @(negedge clk);
    check(!respValid, "R1 one-cycle", {31'b0, respValid}, 32'h0);

    // R2/R3: fill all 64 ways, way k of each set global when k==1
    for (int s = 0; s < 16; s++)
      for (int k = 0; k < 4; k++)
        fill(vpnAt(k, s), 1'b0, entOf(vpnAt(k, s), k == 1, 1'b1), 1'b0);
    for (int s = 0; s < 16; s++)
      for (int k = 0; k < 4; k++) begin
        expectHit(vpnAt(k, s), entOf(vpnAt(k, s), k == 1, 1'b1), "R3 sweep");
        check(gotEnt == entOf(vpnAt(k, s), k == 1, 1'b1), "R3 entry", gotEnt, entOf(vpnAt(k, s), k == 1, 1'b1));
      end
    for (int s = 0; s < 16; s++) expectMiss(vpnAt(4, s), "R2 fifth tag");

    // R9: lookup during flush sees old contents, then only globals remain
    look(vpnAt(0, 7), 12'h010, 1'b0, 1'b1);
    check(gotHit, "R9 same-cycle lookup", {31'b0, gotHit}, 32'h1);
    for (int s = 0; s < 16; s++)
      for (int k = 0; k < 4; k++)
        if (k == 1) expectHit(vpnAt(k, s), entOf(vpnAt(k, s), 1'b1, 1'b1), "R9 global kept");
        else expectMiss(vpnAt(k, s), "R9 flushed");

    // R6: invalid ways used before the global survivor of set 3
    for (int j = 0; j < 3; j++)
      fill({16'h7000 + 16'(j), 4'd3}, 1'b0, entOf({16'h7000 + 16'(j), 4'd3}, 1'b0, 1'b1), 1'b0);
    expectHit(vpnAt(1, 3), entOf(vpnAt(1, 3), 1'b1, 1'b1), "R6 global not evicted");
    for (int j = 0; j < 3; j++)
      expectHit({16'h7000 + 16'(j), 4'd3}, entOf({16'h7000 + 16'(j), 4'd3}, 1'b0, 1'b1), "R6 filled");

    // R7: tree victim in set 5 after a fresh reset
    doReset();
    for (int k = 0; k < 4; k++) fill(vpnAt(k, 5), 1'b0, entOf(vpnAt(k, 5), 1'b0, 1'b1), 1'b0);
    expectHit(vpnAt(0, 5), entOf(vpnAt(0, 5), 1'b0, 1'b1), "R7 touch way0");
    fill(vpnAt(4, 5), 1'b0, entOf(vpnAt(4, 5), 1'b0, 1'b1), 1'b0); // expected victim: way 2
    expectMiss(vpnAt(2, 5), "R7 victim way2");
    expectHit(vpnAt(0, 5), entOf(vpnAt(0, 5), 1'b0, 1'b1), "R7 way0 kept");
    expectHit(vpnAt(1, 5), entOf(vpnAt(1, 5), 1'b0, 1'b1), "R7 way1 kept");
    expectHit(vpnAt(3, 5), entOf(vpnAt(3, 5), 1'b0, 1'b1), "R7 way3 kept");
    expectHit(vpnAt(4, 5), entOf(vpnAt(4, 5), 1'b0, 1'b1), "R7 new entry");

    // R5: refill of a resident tag replaces it in place
    fill(vpnAt(1, 5), 1'b0, {20'hBEEF1, 12'h041}, 1'b0);
    expectHit(vpnAt(1, 5), {20'hBEEF1, 12'h041}, "R5 new frame");
    expectHit(vpnAt(0, 5), entOf(vpnAt(0, 5), 1'b0, 1'b1), "R5 neighbour kept");
    expectHit(vpnAt(3, 5), entOf(vpnAt(3, 5), 1'b0, 1'b1), "R5 neighbour kept");
    expectHit(vpnAt(4, 5), entOf(vpnAt(4, 5), 1'b0, 1'b1), "R5 neighbour kept");

    // R4: directory-kind entries
    fill(20'h3333A, 1'b1, 32'hCAFE0003, 1'b0);
    look(20'h3333A, 12'h055, 1'b0, 1'b0);
    check(!gotHit && gotDir, "R4 dir only", {30'b0, gotHit, gotDir}, 32'h1);
    check(gotEnt == 32'hCAFE0003 && gotPa == 32'h0, "R4 dir entry", gotEnt, 32'hCAFE0003);
    fill(20'h3333A, 1'b0, entOf(20'h3333A, 1'b0, 1'b1), 1'b0);
    look(20'h3333A, 12'h055, 1'b0, 1'b0);
    check(gotHit && gotDir, "R4 both kinds", {30'b0, gotHit, gotDir}, 32'h3);
    check(gotEnt == entOf(20'h3333A, 1'b0, 1'b1), "R4 table preferred", gotEnt, entOf(20'h3333A, 1'b0, 1'b1));

    // R8: writes against clean and dirty pages
    fill(20'h4444B, 1'b0, entOf(20'h4444B, 1'b0, 1'b0), 1'b0);
    look(20'h4444B, 12'h001, 1'b1, 1'b0);
    check(gotV && !gotHit, "R8 clean write", {31'b0, gotHit}, 32'h0);
    look(20'h4444B, 12'h001, 1'b0, 1'b0);
    check(gotHit, "R8 clean read", {31'b0, gotHit}, 32'h1);
    look(20'h3333A, 12'h002, 1'b1, 1'b0);
    check(gotHit && gotPa == {frameOf(20'h3333A), 12'h002}, "R8 dirty write", gotPa, {frameOf(20'h3333A), 12'h002});

    // R10: a global fill beside a flush is dropped
    fill(20'h5555C, 1'b0, entOf(20'h5555C, 1'b1, 1'b1), 1'b1);
    expectMiss(20'h5555C, "R10 fill dropped");
    expectMiss(20'h4444B, "R10 flush applied");

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule